// File: doc/BRIEF.md
# Pipelined Booth Multiply-Accumulate Element

This block is the arithmetic cell of an INT8 neural-network accelerator. On each cycle with its valid input high it takes two signed 8-bit Q1.7 operands and adds their product into a wide signed accumulator. A clear flag sent with a sample starts a new dot product: the product of that sample replaces the accumulated value instead of being added to it. The accumulator holds Q2.14 products sign-extended to its full width.

The multiplier recodes the second operand into radix-4 Booth digits and forms one partial product per digit. A negative digit gives an inverted partial product and a separate vector of correction bits. A Wallace-style carry-save tree compresses these partial products to a sum and carry pair. The last stage merges the pair with the old accumulator through one more 3:2 compressor. A Kogge-Stone prefix adder then finishes the carry propagation. Each stage is registered, and a valid flag and the clear flag travel with the data, so the element accepts one sample on every cycle.

Top module: `booth_mac_pe`

## Requirements
- R1: While reset is asserted, and until the first accepted sample leaves the pipeline, `acc_out` is 0 and `out_valid` is 0.
- R2: A sample accepted at rising edge k (`in_valid`=1) updates `acc_out` and raises `out_valid` at rising edge k+2. `out_valid` is high for exactly one cycle per accepted sample.
- R3: An accepted sample with `clear`=0 sets `acc_out` to the previous `acc_out` plus the signed product of `a` and `b` (both two's complement, 8 bits), sign-extended to the accumulator width.
- R4: An accepted sample with `clear`=1 sets `acc_out` to the signed product of `a` and `b`, and the old value is discarded.
- R5: When `in_valid`=0, the values of `a`, `b` and `clear` have no effect: `acc_out` keeps its value and `out_valid` stays 0 for that sample.
- R6: The accumulator wraps modulo 2^AW (two's complement) when a sum goes past its range.
- R7: Products are exact for all operand pairs, including -128 x -128 = +16384, -128 x 127 = -16256, and every Booth digit pattern of `b`.
- R8: Samples accepted on consecutive cycles are all accumulated, with no stall and no lost sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Sample present on `a`, `b`, `clear` |
| clear | input | 1 | Start a new sum with this sample's product |
| a | input | DW | Multiplicand, signed Q1.7 |
| b | input | DW | Multiplier (Booth-recoded), signed Q1.7 |
| acc_out | output | AW | Accumulated sum, signed Q(AW-14).14 |
| out_valid | output | 1 | `acc_out` was updated by a sample at the last edge |

## Verification
Clear and accumulate are the two functions that can meet in the final stage. A sample flagged with clear can follow an accumulating sample on the next cycle, so one sum ends and a new one starts on back-to-back edges. Bursts with random valid gaps and random clear flags provoke this, as do clears driven while `in_valid` is low and earlier samples are still in flight. A behavioural model with a queue of pending samples judges every cycle. It checks that each clear discards exactly the old sum and no in-flight product, and that a clear on an idle cycle changes nothing.

// File: rtl/bmac_pkg.sv
package bmac_pkg;
  localparam int OP_W  = 8;
  localparam int ACC_W = 24;

  typedef enum logic [2:0] {
    BD_ZERO, BD_POS1, BD_POS2, BD_NEG1, BD_NEG2
  } booth_digit_e;

  // triple = {b[2i+1], b[2i], b[2i-1]}
  function automatic booth_digit_e booth_decode(input logic [2:0] triple);
    case (triple)
      3'b001, 3'b010: return BD_POS1;
      3'b011:         return BD_POS2;
      3'b100:         return BD_NEG2;
      3'b101, 3'b110: return BD_NEG1;
      default:        return BD_ZERO;
    endcase
  endfunction
endpackage

// File: rtl/bmac_csa32.sv
module bmac_csa32 #(
  parameter int W = 24
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  output logic [W-1:0] s,
  output logic [W-1:0] c
);
  assign s = x ^ y ^ z;
  assign c[0] = 1'b0;
  assign c[W-1:1] = (x[W-2:0] & y[W-2:0]) | (x[W-2:0] & z[W-2:0]) |
                    (y[W-2:0] & z[W-2:0]);
endmodule

// File: rtl/bmac_csa_tree.sv
module bmac_csa_tree #(
  parameter int N = 5,
  parameter int W = 24
) (
  input  logic [N-1:0][W-1:0] ops,
  output logic [W-1:0]        sum,
  output logic [W-1:0]        carry
);
  localparam int GRP = N / 3;
  localparam int REM = N % 3;
  localparam int M   = 2 * GRP + REM;

  generate
    if (N == 1) begin : g_one
      assign sum   = ops[0];
      assign carry = '0;
    end else if (N == 2) begin : g_two
      assign sum   = ops[0];
      assign carry = ops[1];
    end else begin : g_level
      logic [M-1:0][W-1:0] lvl;
      for (genvar g = 0; g < GRP; g++) begin : g_csa
        bmac_csa32 #(.W(W)) u_csa (
          .x(ops[3*g]), .y(ops[3*g+1]), .z(ops[3*g+2]),
          .s(lvl[2*g]), .c(lvl[2*g+1])
        );
      end
      for (genvar r = 0; r < REM; r++) begin : g_pass
        assign lvl[2*GRP+r] = ops[3*GRP+r];
      end
      bmac_csa_tree #(.N(M), .W(W)) u_next (
        .ops(lvl), .sum(sum), .carry(carry)
      );
    end
  endgenerate
endmodule

// File: rtl/bmac_booth_pp.sv
module bmac_booth_pp #(
  parameter int DW = 8,
  parameter int AW = 24,
  localparam int ND = DW / 2
) (
  input  logic [DW-1:0]        a,
  input  logic [DW-1:0]        b,
  output logic [ND:0][AW-1:0]  ops   // ND partial products + correction vector
);
  import bmac_pkg::*;

  logic [DW:0]   bx;
  logic [AW-1:0] a_ext;
  logic [AW-1:0] mag;
  logic [AW-1:0] corr;
  booth_digit_e  dig;

  assign bx    = {b, 1'b0};
  assign a_ext = {{(AW-DW){a[DW-1]}}, a};

  always_comb begin
    corr = '0;
    mag  = '0;
    dig  = BD_ZERO;
    for (int i = 0; i < ND; i++) begin
      dig = booth_decode(bx[2*i +: 3]);
      case (dig)
        BD_POS1, BD_NEG1: mag = a_ext;
        BD_POS2, BD_NEG2: mag = {a_ext[AW-2:0], 1'b0};
        default:          mag = '0;
      endcase
      if (dig == BD_NEG1 || dig == BD_NEG2) begin
        ops[i] = (~mag) << (2*i);
        corr[2*i] = 1'b1;
      end else begin
        ops[i] = mag << (2*i);
      end
    end
    ops[ND] = corr;
  end
endmodule

// File: rtl/bmac_ks_adder.sv
module bmac_ks_adder #(
  parameter int W = 24,
  localparam int L = $clog2(W)
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] s
);
  logic [W-1:0] gg, pp, gn, pn;

  always_comb begin
    gg = x & y;
    pp = x ^ y;
    gn = gg;
    pn = pp;
    for (int lv = 0; lv < L; lv++) begin
      gn = gg;
      pn = pp;
      for (int j = 0; j < W; j++) begin
        if (j >= (1 << lv)) begin
          gn[j] = gg[j] | (pp[j] & gg[j - (1 << lv)]);
          pn[j] = pp[j] & pp[j - (1 << lv)];
        end
      end
      gg = gn;
      pp = pn;
    end
    s = (x ^ y) ^ {gg[W-2:0], 1'b0};
  end
endmodule

// File: rtl/booth_mac_pe.sv
module booth_mac_pe #(
  parameter int DW = bmac_pkg::OP_W,
  parameter int AW = bmac_pkg::ACC_W,
  localparam int ND   = DW / 2,
  localparam int NOPS = ND + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          clear,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [AW-1:0] acc_out,
  output logic          out_valid
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign srst_n = rst_q[1];

  // stage 1: Booth recoding and partial products
  logic [NOPS-1:0][AW-1:0] pp_d, s1_ops_q;
  logic                    s1_v_q, s1_clr_q, s1_en;

  bmac_booth_pp #(.DW(DW), .AW(AW)) u_pp (.a(a), .b(b), .ops(pp_d));

  assign s1_en = in_valid;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) s1_v_q <= 1'b0;
    else         s1_v_q <= in_valid;
  end
  always_ff @(posedge clk) begin
    if (s1_en) begin
      s1_ops_q <= pp_d;
      s1_clr_q <= clear;
    end
  end

  // stage 2: carry-save reduction
  logic [AW-1:0] t_sum, t_car, s2_sum_q, s2_car_q;
  logic          s2_v_q, s2_clr_q, s2_en;

  bmac_csa_tree #(.N(NOPS), .W(AW)) u_tree (
    .ops(s1_ops_q), .sum(t_sum), .carry(t_car)
  );

  assign s2_en = s1_v_q;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) s2_v_q <= 1'b0;
    else         s2_v_q <= s1_v_q;
  end
  always_ff @(posedge clk) begin
    if (s2_en) begin
      s2_sum_q <= t_sum;
      s2_car_q <= t_car;
      s2_clr_q <= s1_clr_q;
    end
  end

  // stage 3: merge with accumulator, prefix add
  logic [AW-1:0] acc_q, acc_base, f_s, f_c, acc_d;
  logic          ov_q, acc_en;

  always_comb begin
    acc_base = s2_clr_q ? '0 : acc_q;
  end

  bmac_csa32 #(.W(AW)) u_merge (
    .x(s2_sum_q), .y(s2_car_q), .z(acc_base), .s(f_s), .c(f_c)
  );
  bmac_ks_adder #(.W(AW)) u_ks (.x(f_s), .y(f_c), .s(acc_d));

  assign acc_en = s2_v_q;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      acc_q <= '0;
      ov_q  <= 1'b0;
    end else begin
      ov_q <= s2_v_q;
      if (acc_en) acc_q <= acc_d;
    end
  end

  assign acc_out   = acc_q;
  assign out_valid = ov_q;
endmodule

// File: rtl/bmac_chk.sv
module bmac_chk #(
  parameter int DW = 8,
  parameter int AW = 24
) (
  input logic          clk,
  input logic          srst_n,
  input logic          in_valid,
  input logic          clear,
  input logic [DW-1:0] a,
  input logic [DW-1:0] b,
  input logic [AW-1:0] acc_out,
  input logic          out_valid
);
  logic signed [2*DW-1:0] prod;
  logic [AW-1:0]          prod_ext;
  logic [2:0]             up;

  assign prod     = $signed(a) * $signed(b);
  assign prod_ext = {{(AW-2*DW){prod[2*DW-1]}}, prod};

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)        up <= '0;
    else if (up != 3'd7) up <= up + 3'd1;
  end

  // R2
  ov_src_chk: assert property (@(posedge clk) disable iff (!srst_n)
    out_valid |-> $past(in_valid, 3));

  // R8
  ov_follow_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (up >= 3'd5 && $past(in_valid, 3)) |-> out_valid);

  // R5
  acc_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !out_valid |-> $stable(acc_out));

  // R4
  clear_load_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (out_valid && $past(clear, 3)) |-> acc_out == $past(prod_ext, 3));

  // R3
  acc_add_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (out_valid && !$past(clear, 3)) |->
      acc_out == $past(acc_out) + $past(prod_ext, 3));
endmodule

bind booth_mac_pe bmac_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .srst_n(srst_n), .in_valid(in_valid), .clear(clear),
  .a(a), .b(b), .acc_out(acc_out), .out_valid(out_valid)
);

// File: tb/test_booth_mac_pe.sv
`timescale 1ns/1ps
module test_booth_mac_pe;
  localparam int DW = 8;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid, clear;
  logic [DW-1:0] a, b;
  logic [AW-1:0] acc_out;
  logic          out_valid;

  int    n_chk = 0, n_fail = 0;
  bit    cmp_on = 1'b0;
  bit    done = 1'b0;
  string tag = "R1";

  always #2 clk = ~clk;

  booth_mac_pe i_booth_mac_pe (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .clear(clear),
    .a(a), .b(b), .acc_out(acc_out), .out_valid(out_valid)
  );

  // reference model: two pending samples, then the accumulator
  logic          p1_v, p1_c, p2_v, p2_c, m_ov;
  logic [AW-1:0] p1_p, p2_p, m_acc;

  function automatic logic [AW-1:0] mulx(logic [DW-1:0] x, logic [DW-1:0] y);
    int r;
    r = int'($signed(x)) * int'($signed(y));
    return r[AW-1:0];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1_v <= 1'b0; p2_v <= 1'b0; m_ov <= 1'b0; m_acc <= '0;
      p1_c <= 1'b0; p2_c <= 1'b0; p1_p <= '0; p2_p <= '0;
    end else begin
      m_ov <= p2_v;
      if (p2_v) m_acc <= (p2_c ? '0 : m_acc) + p2_p;
      p2_v <= p1_v; p2_c <= p1_c; p2_p <= p1_p;
      p1_v <= in_valid; p1_c <= clear; p1_p <= mulx(a, b);
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      n_chk++;
      if (acc_out !== m_acc || out_valid !== m_ov) begin
        n_fail++;
        $display("FAIL %s: acc_out=%h out_valid=%b expected acc=%h valid=%b",
                 tag, acc_out, out_valid, m_acc, m_ov);
      end
    end
  end

  task automatic push(input bit v, input bit c, input logic [DW-1:0] x,
                      input logic [DW-1:0] y);
    @(negedge clk);
    in_valid = v; clear = c; a = x; b = y;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) push(1'b0, 1'b0, 8'h00, 8'h00);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; clear = 1'b0; a = '0; b = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    n_chk++;
    if (acc_out !== '0 || out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: acc_out=%h out_valid=%b expected 0 0", acc_out, out_valid);
    end
    rst_n = 1'b1;
    cmp_on = 1'b1;
    idle(5);

    // R2: single sample latency
    tag = "R2";
    push(1'b1, 1'b1, 8'h03, 8'h05);
    idle(5);

    // R7: extremes and every Booth pattern of b
    tag = "R7";
    push(1'b1, 1'b1, 8'h80, 8'h80);
    push(1'b1, 1'b0, 8'h80, 8'h7f);
    push(1'b1, 1'b0, 8'h7f, 8'h80);
    push(1'b1, 1'b0, 8'h7f, 8'h7f);
    push(1'b1, 1'b0, 8'hff, 8'hff);
    for (int k = 0; k < 256; k++) push(1'b1, 1'b0, 8'h80, k[7:0]);
    for (int k = 0; k < 256; k++) push(1'b1, 1'b0, 8'h55, k[7:0]);
    idle(4);

    // R3 / R8: back-to-back random accumulation
    tag = "R3_R8";
    push(1'b1, 1'b1, 8'h11, 8'h22);
    for (int k = 0; k < 200; k++)
      push(1'b1, 1'b0, 8'($urandom), 8'($urandom));
    idle(4);

    // R5: idle cycles with clear and data toggling
    tag = "R5";
    for (int k = 0; k < 12; k++)
      push(1'b0, 1'b1, 8'($urandom), 8'($urandom));
    idle(2);

    // R4: random gaps and random clears, including back-to-back clear
    tag = "R4";
    push(1'b1, 1'b0, 8'h40, 8'h40);
    push(1'b1, 1'b1, 8'hc0, 8'h40);
    for (int k = 0; k < 250; k++)
      push(($urandom % 10) < 7, ($urandom % 8) == 0,
           8'($urandom), 8'($urandom));
    idle(4);

    // R6: wrap past the top of the accumulator
    tag = "R6";
    push(1'b1, 1'b1, 8'h80, 8'h80);
    for (int k = 0; k < 1100; k++) push(1'b1, 1'b0, 8'h80, 8'h80);
    idle(4);

    cmp_on = 1'b0;
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not end, expected end before 200000 cycles");
      summary();
      $finish;
    end
  end
endmodule